// File: doc/BRIEF.md
# Two-bit overlay pixel expander

This block turns a packed overlay bitmap, stored at two bits per pixel, into a stream of 32-bit RGBA pixels. Each byte taken from overlay memory holds four pixels. Of the two bits of a pixel, one picks which of two programmed colours to use. The other is a coverage bit that either keeps the colour's alpha byte or forces it to zero. Two configuration bits set the order of the pixels inside a byte and the role of each bit inside a pixel.

Bytes arrive on a valid/ready input. Pixels leave on a valid/ready output, one per accepted handshake. A line is `cfg_width` pixels wide. In memory it takes a stride of bytes that is padded to a multiple of four. The block consumes the whole stride. It drops the unused pixel slots of the last active byte and swallows the padding bytes without producing output.

The controller has three states:
- `ST_LOAD`: waits for a byte.
- `ST_EMIT`: presents the four slots of the held byte.
- `ST_PAD`: consumes padding bytes.

Its transitions are:
- LOAD→EMIT when a byte is accepted.
- EMIT→EMIT on a pixel handshake that is neither the byte's fourth slot nor the line's last pixel.
- EMIT→LOAD after the fourth slot, or after the line's last pixel when its byte ends the stride.
- EMIT→PAD after the line's last pixel when stride bytes remain.
- PAD→PAD on a padding byte that is not the stride's final byte.
- PAD→LOAD when the stride's final byte is accepted.

Top module: `ovl2_expander`

## Requirements
- R1: After reset, `px_valid` and `px_last` are 0 and `in_ready` is 1.
- R2: Colours use the layout red [7:0], green [15:8], blue [23:16], alpha [31:24]. The pixel's colour bit chooses the source: `cfg_color1` when the bit is 1, `cfg_color0` when it is 0. Bits [23:0] of `px_rgba` equal bits [23:0] of the chosen colour.
- R3: When the coverage bit is 0, `px_rgba[31:24]` is 0. When it is 1, `px_rgba[31:24]` is the alpha byte of the chosen colour.
- R4: Call a pixel's 2-bit field f, with f[1] its upper bit. With `cfg_ac_order`=0, f[1] is the colour bit and f[0] the coverage bit. With `cfg_ac_order`=1, f[1] is the coverage bit and f[0] the colour bit.
- R5: With `cfg_lsb_first`=0, pixel k of a byte (k=0..3) uses bits [7-2k:6-2k], so the first pixel sits in bits [7:6]. With `cfg_lsb_first`=1, pixel k uses bits [2k+1:2k].
- R6: Each accepted byte yields up to four pixels, in order. `in_ready` and `px_valid` are never both 1. While `px_valid` is 1 and `px_ready` is 0, `px_valid` and `px_rgba` hold.
- R7: A line of W pixels (W ≥ 1) occupies ceil(ceil(W/4)/4)*4 input bytes. Bytes after the last active byte are accepted and produce no pixel.
- R8: Exactly W pixels are emitted per line. Slots past pixel W-1 in the last active byte are dropped. `px_last` is 1 only with pixel W-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_color0 | input | 32 | Colour used when the colour bit is 0 |
| cfg_color1 | input | 32 | Colour used when the colour bit is 1 |
| cfg_ac_order | input | 1 | Bit roles within a pixel (0: colour then coverage, 1: coverage then colour) |
| cfg_lsb_first | input | 1 | Pixel order within a byte (0: first pixel in MSBs, 1: first pixel in LSBs) |
| cfg_width | input | WIDTH_BITS | Active pixels per line, at least 1 |
| in_valid | input | 1 | Input byte valid |
| in_byte | input | 8 | Packed overlay byte |
| in_ready | output | 1 | Block accepts a byte this cycle |
| px_valid | output | 1 | Output pixel valid |
| px_ready | input | 1 | Consumer accepts the pixel |
| px_rgba | output | 32 | Expanded pixel |
| px_last | output | 1 | Pixel is the last active pixel of the line |

## Verification
The bench builds the block with its default `WIDTH_BITS` of 12. At that size the line widths it uses cover several padding cases:
- 16 pixels: no padding.
- 5 pixels: two padding bytes plus three dropped slots.
- 17 pixels: three padding bytes.
- 1 pixel: three dropped slots and three padding bytes.

Lines run back to back, so the return from `ST_PAD` to a fresh line is exercised. The bench also combines all four settings of the two ordering bits with colours whose alpha bytes differ, and throttles `px_ready` to hold pixels under backpressure.

// File: rtl/ovl2_pkg.sv
package ovl2_pkg;
    typedef enum logic [1:0] {
        ST_LOAD = 2'd0,
        ST_EMIT = 2'd1,
        ST_PAD  = 2'd2
    } ovl2_state_e;

    localparam int PIX_PER_BYTE = 4;
    localparam int SLOT_BITS    = 2;
    localparam int STRIDE_ALIGN = 4;
endpackage

// File: rtl/ovl2_stride.sv
module ovl2_stride #(
    parameter int WIDTH_BITS = 12
) (
    input  logic [WIDTH_BITS-1:0] width_px,
    output logic [WIDTH_BITS-1:0] stride_last
);
    localparam int EXT = WIDTH_BITS + 2;
    logic [EXT-1:0] act_bytes;
    logic [EXT-1:0] stride;

    always_comb begin
        act_bytes   = ({2'b00, width_px} + EXT'(ovl2_pkg::PIX_PER_BYTE - 1)) >> 2;
        stride      = (act_bytes + EXT'(ovl2_pkg::STRIDE_ALIGN - 1)) & ~EXT'(ovl2_pkg::STRIDE_ALIGN - 1);
        stride_last = WIDTH_BITS'(stride - EXT'(1));
    end
endmodule

// File: rtl/ovl2_decode.sv
module ovl2_decode (
    input  logic [7:0]  byte_in,
    input  logic [1:0]  slot,
    input  logic        lsb_first,
    input  logic        ac_order,
    input  logic [31:0] color0,
    input  logic [31:0] color1,
    output logic [31:0] rgba
);
    logic [1:0]  fld;
    logic [2:0]  lo;
    logic        sel_bit;
    logic        cov_bit;
    logic [31:0] chosen;

    always_comb begin
        lo      = lsb_first ? {slot, 1'b0} : {~slot, 1'b0};
        fld     = byte_in[lo +: 2];
        sel_bit = ac_order ? fld[0] : fld[1];
        cov_bit = ac_order ? fld[1] : fld[0];
        chosen  = sel_bit ? color1 : color0;
        rgba    = {cov_bit ? chosen[31:24] : 8'h00, chosen[23:0]};
    end
endmodule

// File: rtl/ovl2_expander.sv
module ovl2_expander #(
    parameter int WIDTH_BITS = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [31:0]           cfg_color0,
    input  logic [31:0]           cfg_color1,
    input  logic                  cfg_ac_order,
    input  logic                  cfg_lsb_first,
    input  logic [WIDTH_BITS-1:0] cfg_width,
    input  logic                  in_valid,
    input  logic [7:0]            in_byte,
    output logic                  in_ready,
    output logic                  px_valid,
    input  logic                  px_ready,
    output logic [31:0]           px_rgba,
    output logic                  px_last
);
    import ovl2_pkg::*;

    ovl2_state_e state, state_nxt;
    logic [7:0]                  held_byte;
    logic [SLOT_BITS-1:0]        slot;
    logic [WIDTH_BITS-1:0]       pix_idx;
    logic [WIDTH_BITS-1:0]       byte_idx;
    logic [WIDTH_BITS-1:0]       stride_last;
    logic                        line_end;
    logic                        in_fire;
    logic                        px_fire;

    ovl2_stride #(.WIDTH_BITS(WIDTH_BITS)) u_stride (
        .width_px    (cfg_width),
        .stride_last (stride_last)
    );

    ovl2_decode u_decode (
        .byte_in   (held_byte),
        .slot      (slot),
        .lsb_first (cfg_lsb_first),
        .ac_order  (cfg_ac_order),
        .color0    (cfg_color0),
        .color1    (cfg_color1),
        .rgba      (px_rgba)
    );

    assign line_end = (pix_idx == cfg_width - WIDTH_BITS'(1));
    assign in_fire  = in_valid && in_ready;
    assign px_fire  = px_valid && px_ready;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_LOAD;
        else        state <= state_nxt;
    end

    // next state
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_LOAD: if (in_valid) state_nxt = ST_EMIT;
            ST_EMIT: begin
                if (px_ready) begin
                    if (line_end)
                        state_nxt = (byte_idx == stride_last) ? ST_LOAD : ST_PAD;
                    else if (slot == SLOT_BITS'(PIX_PER_BYTE - 1))
                        state_nxt = ST_LOAD;
                end
            end
            ST_PAD: if (in_valid && (byte_idx + WIDTH_BITS'(1) == stride_last)) state_nxt = ST_LOAD;
            default: state_nxt = ST_LOAD;
        endcase
    end

    // outputs
    always_comb begin
        in_ready = 1'b0;
        px_valid = 1'b0;
        px_last  = 1'b0;
        unique case (state)
            ST_LOAD: in_ready = 1'b1;
            ST_EMIT: begin
                px_valid = 1'b1;
                px_last  = line_end;
            end
            ST_PAD:  in_ready = 1'b1;
            default: ;
        endcase
    end

    // datapath counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_byte <= '0;
            slot      <= '0;
            pix_idx   <= '0;
            byte_idx  <= '0;
        end else begin
            if (in_fire && state == ST_LOAD) begin
                held_byte <= in_byte;
                slot      <= '0;
                byte_idx  <= (pix_idx == '0) ? '0 : byte_idx + WIDTH_BITS'(1);
            end
            if (in_fire && state == ST_PAD)
                byte_idx <= byte_idx + WIDTH_BITS'(1);
            if (px_fire) begin
                slot    <= slot + SLOT_BITS'(1);
                pix_idx <= line_end ? '0 : pix_idx + WIDTH_BITS'(1);
            end
        end
    end
endmodule

// File: rtl/ovl2_expander_chk.sv
module ovl2_expander_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] cfg_color0,
    input logic [31:0] cfg_color1,
    input logic        in_ready,
    input logic        px_valid,
    input logic        px_ready,
    input logic [31:0] px_rgba,
    input logic        px_last
);
    AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> (in_ready && !px_valid)); // R1
    AST_RGB_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        px_valid |-> (px_rgba[23:0] == cfg_color0[23:0] || px_rgba[23:0] == cfg_color1[23:0])); // R2
    AST_ALPHA_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        px_valid |-> (px_rgba[31:24] == 8'h00 || px_rgba[31:24] == cfg_color0[31:24]
                      || px_rgba[31:24] == cfg_color1[31:24])); // R3
    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n) !(in_ready && px_valid)); // R6
    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (px_valid && !px_ready) |=> (px_valid && $stable(px_rgba))); // R6
    AST_LAST_QUAL: assert property (@(posedge clk) disable iff (!rst_n) px_last |-> px_valid); // R8
endmodule

bind ovl2_expander ovl2_expander_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_color0 (cfg_color0),
    .cfg_color1 (cfg_color1),
    .in_ready   (in_ready),
    .px_valid   (px_valid),
    .px_ready   (px_ready),
    .px_rgba    (px_rgba),
    .px_last    (px_last)
);

// File: tb/ovl2_expander_bench.sv
module ovl2_expander_bench;
    localparam int WB = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [31:0]   cfg_color0 = 32'h0;
    logic [31:0]   cfg_color1 = 32'h0;
    logic          cfg_ac_order = 1'b0;
    logic          cfg_lsb_first = 1'b0;
    logic [WB-1:0] cfg_width = WB'(4);
    logic          in_valid = 1'b0;
    logic [7:0]    in_byte = 8'h0;
    logic          in_ready;
    logic          px_valid;
    logic          px_ready = 1'b0;
    logic [31:0]   px_rgba;
    logic          px_last;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    always #10 clk = ~clk;

    ovl2_expander #(.WIDTH_BITS(WB)) u_ovl2_expander (
        .clk(clk), .rst_n(rst_n), .cfg_color0(cfg_color0), .cfg_color1(cfg_color1),
        .cfg_ac_order(cfg_ac_order), .cfg_lsb_first(cfg_lsb_first), .cfg_width(cfg_width),
        .in_valid(in_valid), .in_byte(in_byte), .in_ready(in_ready),
        .px_valid(px_valid), .px_ready(px_ready), .px_rgba(px_rgba), .px_last(px_last)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run hung, actual cycles=%0d expected<150000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] gen_byte(input int seed, input int idx);
        return 8'((seed * 37) ^ (idx * 91) ^ (idx << 3));
    endfunction

    // Expected pixel from requirements R2..R5
    function automatic logic [31:0] exp_pix(input logic [7:0] b, input int k,
                                            input logic lsbf, input logic aco,
                                            input logic [31:0] c0, input logic [31:0] c1);
        logic [1:0]  f;
        logic        cbit, abit;
        logic [31:0] c;
        f    = lsbf ? b[2*k +: 2] : b[(6 - 2*k) +: 2];
        cbit = aco ? f[0] : f[1];
        abit = aco ? f[1] : f[0];
        c    = cbit ? c1 : c0;
        return {abit ? c[31:24] : 8'h00, c[23:0]};
    endfunction

    // One line: R7 byte count, R8 pixel count/last, R6 stall hold
    task automatic run_line(input string name, input int w, input int seed,
                            input logic lsbf, input logic aco, input bit throttle);
        int stride, bi, pi, guard;
        logic [7:0] mem [0:1023];
        bit stalled;
        logic [31:0] stall_data;
        stride = (((w + 3) / 4 + 3) / 4) * 4;
        for (int i = 0; i < stride; i++) mem[i] = gen_byte(seed, i);
        cfg_width = WB'(w);
        cfg_lsb_first = lsbf;
        cfg_ac_order = aco;
        bi = 0; pi = 0; guard = 0; stalled = 0; stall_data = '0;
        @(negedge clk);
        while ((bi < stride || pi < w) && guard < 4000) begin
            in_valid = (bi < stride);
            in_byte  = (bi < stride) ? mem[bi] : 8'h00;
            px_ready = throttle ? ((guard % 3) != 1) : 1'b1;
            #1;
            if (stalled) begin
                check({name, " R6 hold valid"}, {31'b0, px_valid}, 32'd1);
                check({name, " R6 hold data"}, px_rgba, stall_data);
            end
            stalled = 0;
            if (px_valid && in_ready) check({name, " R6 exclusive"}, 32'd1, 32'd0);
            if (in_valid && in_ready) bi++;
            if (px_valid) begin
                if (!px_ready) begin
                    stalled = 1;
                    stall_data = px_rgba;
                end else if (pi >= w) begin
                    check({name, " R8 extra pixel"}, pi, w);
                    pi++;
                end else begin
                    check({name, " R2/R3/R4/R5 pixel"}, px_rgba,
                          exp_pix(mem[pi / 4], pi % 4, lsbf, aco, cfg_color0, cfg_color1));
                    check({name, " R8 last flag"}, {31'b0, px_last}, {31'b0, (pi == w - 1)});
                    pi++;
                end
            end
            @(negedge clk);
            guard++;
        end
        in_valid = 1'b0;
        check({name, " R7 bytes consumed"}, bi, stride);
        check({name, " R8 pixel count"}, pi, w);
        repeat (3) @(negedge clk);
        check({name, " R7 idle after stride"}, {30'b0, in_ready, px_valid}, 32'b10);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("reset R1 in_ready", {31'b0, in_ready}, 32'd1);
        check("reset R1 px_valid", {31'b0, px_valid}, 32'd0);
        check("reset R1 px_last", {31'b0, px_last}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_known_byte;
        // byte 8'b11_10_01_00, big endian, CA: colour bit upper, coverage lower
        logic [7:0] b;
        b = 8'b1110_0100;
        cfg_width = WB'(16);
        cfg_lsb_first = 1'b0;
        cfg_ac_order = 1'b0;
        in_valid = 1'b1;
        in_byte = b;
        px_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("known R5 first slot 11", px_rgba, cfg_color1);
        @(negedge clk);
        check("known R3 slot 10 alpha zero", px_rgba, {8'h00, cfg_color1[23:0]});
        @(negedge clk);
        check("known R2 slot 01 colour0", px_rgba, cfg_color0);
        @(negedge clk);
        check("known R4 slot 00", px_rgba, {8'h00, cfg_color0[23:0]});
        @(negedge clk);
        // finish the rest of the 16-pixel line (3 bytes remain)
        for (int j = 0; j < 3; j++) begin
            in_valid = 1'b1;
            in_byte = 8'h00;
            @(negedge clk);
            in_valid = 1'b0;
            repeat (4) @(negedge clk);
        end
        check("known R7 line closed", {31'b0, in_ready}, 32'd1);
    endtask

    initial begin
        cfg_color0 = 32'h11_22_33_44;
        cfg_color1 = 32'hA5_C6_E7_08;
        t_reset();
        t_known_byte();
        run_line("w16 be ca", 16, 1, 1'b0, 1'b0, 1'b0);
        run_line("w16 le ca", 16, 2, 1'b1, 1'b0, 1'b0);
        run_line("w16 be ac", 16, 3, 1'b0, 1'b1, 1'b0);
        run_line("w16 le ac", 16, 4, 1'b1, 1'b1, 1'b0);
        run_line("w5 pad",    5,  5, 1'b0, 1'b0, 1'b0);
        run_line("w17 pad",   17, 6, 1'b1, 1'b1, 1'b0);
        run_line("w1 pad",    1,  7, 1'b0, 1'b1, 1'b0);
        run_line("w33 stall", 33, 8, 1'b1, 1'b0, 1'b1);
        cfg_color0 = 32'hFF_00_80_01;
        cfg_color1 = 32'h00_7F_7F_7F;
        run_line("w21 colours", 21, 9, 1'b0, 1'b0, 1'b1);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule